// File: doc/BRIEF.md
# Ordered Bus and Differential Clock Stop Controller

This block gates a set of 33 MHz bus clocks and one 100 MHz differential clock pair when an active-low stop request arrives. The request can come from a pin or from a register bit. A free-running bus clock samples it, and each gated clock's own domain picks it up through a synchronizer. Stopping follows a fixed order. The stoppable bus clocks are held low first, each starting at a falling edge. Once every one of them is held, the differential pair parks on a rising edge with its true leg high and its complement leg low. Alternatively, the pair can be released to high impedance through an output-enable.

Resuming runs in the reverse order. The differential pair restarts first, and the bus clocks are released after it. No output pulse is ever shortened. Each clock has a configuration bit that makes it free-running, and a free-running clock ignores every stop source. Two status outputs, both in the free-running bus clock domain, report when the stoppable clocks are fully parked and when all of them are running again.

Top module: `clkstop_ctrl`

## Requirements
- R1: The stop request is active when `stop_n_i` is 0 or `stop_reg_i` is 1, and either source alone stops the stoppable clocks.
- R2: The stop request is sampled only on rising edges of `bus_free_clk_i`, so a pin pulse that begins and ends between two such edges has no effect.
- R3: A stoppable bus clock output is held low starting at a falling edge of its input, and every high phase it produces lasts exactly half an input period.
- R4: The differential pair parks only while every stoppable bus output is already held low. When parked, `diff_p_o` is 1 and `diff_n_o` is 0, and `diff_n_o` is always the inverse of `diff_p_o`.
- R5: `diff_oe_o` is 0 while the pair is parked with `float_cfg_i` set to 1. It is 1 whenever the pair is not parked or `float_cfg_i` is 0.
- R6: A bus clock whose bit in `bus_free_cfg_i` is 1, or the pair when `diff_free_cfg_i` is 1, keeps toggling regardless of either stop source.
- R7: After the request is removed, the differential pair restarts before any stoppable bus clock does. Every restarted output begins with full-width phases.
- R8: `stopped_o` is 1 when every stoppable clock is parked. `running_o` is 1 when no clock is parked. Both change only on `bus_free_clk_i` rising edges.
- R9: After reset, all clocks run, `diff_oe_o` is 1, `running_o` is 1 and `stopped_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_free_clk_i | input | 1 | Free-running 33 MHz bus clock that samples the request |
| bus_clk_i | input | NUM_BUS | Bus clocks to be gated |
| diff_clk_i | input | 1 | 100 MHz clock that drives the differential pair |
| rst_ni | input | 1 | Active-low reset, asynchronous assert |
| stop_n_i | input | 1 | Active-low stop request pin |
| stop_reg_i | input | 1 | Stop request from a control register, active high |
| bus_free_cfg_i | input | NUM_BUS | 1 marks the matching bus clock free-running |
| diff_free_cfg_i | input | 1 | 1 marks the differential pair free-running |
| float_cfg_i | input | 1 | 1 releases the parked pair to high impedance |
| bus_clk_o | output | NUM_BUS | Gated bus clocks |
| diff_p_o | output | 1 | Gated true leg of the pair |
| diff_n_o | output | 1 | Gated complement leg of the pair |
| diff_oe_o | output | 1 | Output-enable for the pair drivers |
| stopped_o | output | 1 | All stoppable clocks parked |
| running_o | output | 1 | No clock parked |

## Verification
The ordering assertions assume three things about the inputs. The differential clock runs faster than the bus clocks. The gated bus clocks share phase with the free-running bus clock. The configuration bits change only while no stop is in progress. Under these conditions the differential domain always sees a stop being withdrawn before the bus domains act on it. The stimulus ties every bus input to the free-running clock and runs the pair at 250 MHz with a 1 ns offset, so no falling bus edge ever lands on a differential rising edge. It changes configuration only after the outputs have settled in the running state.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/100ps
package clkstop_pkg;
  localparam int unsigned DEF_SYNC_DEPTH = 2;

  // Request pair carried into a gated clock domain
  typedef struct packed {
    logic stop;   // sampled stop request
    logic hold;   // ordering hold from the neighbouring domain
  } xreq_t;

  localparam int unsigned XREQ_W = $bits(xreq_t);
endpackage

// File: rtl/clkstop_sync.sv
`timescale 1ns/100ps
module clkstop_sync #(
  parameter int unsigned WIDTH = 1,
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = d_i;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_d;
    end
  end

  assign q_o = stage_q[DEPTH-1];
endmodule

// File: rtl/clkstop_bus_gate.sv
`timescale 1ns/100ps
module clkstop_bus_gate
  import clkstop_pkg::*;
#(
  parameter int unsigned SYNC_DEPTH = DEF_SYNC_DEPTH
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic free_i,
  input  logic stop_i,
  input  logic hold_i,
  output logic clk_o,
  output logic parked_o
);
  xreq_t req_raw;
  xreq_t req_s;
  logic  stop_req;
  logic  en_d;
  logic  en_q;

  assign req_raw.stop = stop_i;
  assign req_raw.hold = hold_i;

  clkstop_sync #(.WIDTH(XREQ_W), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (req_raw),
    .q_o    (req_s)
  );

  // Stay stopped while the pair is parked, so release waits for it
  always_comb begin
    stop_req = ~free_i & (req_s.stop | req_s.hold);
    en_d     = ~stop_req;
  end

  // Enable moves only on a falling edge: the output is low at that moment
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b1;
    else         en_q <= en_d;
  end

  assign clk_o    = clk_i & en_q;
  assign parked_o = ~en_q;

  assert_bus_free_runs_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(free_i) && free_i) |-> en_q);

  assert_bus_park_on_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_q) |-> stop_req);
endmodule

// File: rtl/clkstop_diff_gate.sv
`timescale 1ns/100ps
module clkstop_diff_gate
  import clkstop_pkg::*;
#(
  parameter int unsigned SYNC_DEPTH = DEF_SYNC_DEPTH
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic free_i,
  input  logic float_i,
  input  logic stop_i,
  input  logic bus_parked_i,
  output logic p_o,
  output logic n_o,
  output logic oe_o,
  output logic parked_o
);
  xreq_t req_raw;
  xreq_t req_s;
  logic  park_d;
  logic  park_q;
  logic  oe_d;
  logic  oe_q;

  assign req_raw.stop = stop_i;
  assign req_raw.hold = bus_parked_i;

  clkstop_sync #(.WIDTH(XREQ_W), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (req_raw),
    .q_o    (req_s)
  );

  // Park only once every stoppable bus clock is held low
  always_comb begin
    park_d = ~free_i & req_s.stop & req_s.hold;
    oe_d   = ~(park_d & float_i);
  end

  // Updates on a rising edge: the true leg is already high there
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      park_q <= 1'b0;
      oe_q   <= 1'b1;
    end else begin
      park_q <= park_d;
      oe_q   <= oe_d;
    end
  end

  assign p_o      = clk_i | park_q;
  assign n_o      = ~(clk_i | park_q);
  assign oe_o     = oe_q;
  assign parked_o = park_q;

  assert_diff_free_runs_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(free_i) |-> !park_q);

  assert_float_oe_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (park_q && $past(float_i)) |-> !oe_q);

  assert_oe_high_running_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !park_q |-> oe_q);
endmodule

// File: rtl/clkstop_ctrl.sv
`timescale 1ns/100ps
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int unsigned NUM_BUS    = 4,
  parameter int unsigned SYNC_DEPTH = DEF_SYNC_DEPTH
) (
  input  logic               bus_free_clk_i,
  input  logic [NUM_BUS-1:0] bus_clk_i,
  input  logic               diff_clk_i,
  input  logic               rst_ni,
  input  logic               stop_n_i,
  input  logic               stop_reg_i,
  input  logic [NUM_BUS-1:0] bus_free_cfg_i,
  input  logic               diff_free_cfg_i,
  input  logic               float_cfg_i,
  output logic [NUM_BUS-1:0] bus_clk_o,
  output logic               diff_p_o,
  output logic               diff_n_o,
  output logic               diff_oe_o,
  output logic               stopped_o,
  output logic               running_o
);
  localparam int unsigned STAT_W = 2;

  logic               stop_d;
  logic               stop_q;
  logic [NUM_BUS-1:0] bus_parked;
  logic               all_bus_parked;
  logic               diff_parked;
  logic [STAT_W-1:0]  stat_raw;
  logic [STAT_W-1:0]  stat_s;

  // Request sampling in the free-running bus domain
  always_comb stop_d = ~stop_n_i | stop_reg_i;

  always_ff @(posedge bus_free_clk_i or negedge rst_ni) begin
    if (!rst_ni) stop_q <= 1'b0;
    else         stop_q <= stop_d;
  end

  for (genvar g = 0; g < NUM_BUS; g++) begin : g_bus
    clkstop_bus_gate #(.SYNC_DEPTH(SYNC_DEPTH)) u_gate (
      .clk_i    (bus_clk_i[g]),
      .rst_ni   (rst_ni),
      .free_i   (bus_free_cfg_i[g]),
      .stop_i   (stop_q),
      .hold_i   (diff_parked),
      .clk_o    (bus_clk_o[g]),
      .parked_o (bus_parked[g])
    );
  end

  assign all_bus_parked = &(bus_parked | bus_free_cfg_i);

  clkstop_diff_gate #(.SYNC_DEPTH(SYNC_DEPTH)) u_diff (
    .clk_i        (diff_clk_i),
    .rst_ni       (rst_ni),
    .free_i       (diff_free_cfg_i),
    .float_i      (float_cfg_i),
    .stop_i       (stop_q),
    .bus_parked_i (all_bus_parked),
    .p_o          (diff_p_o),
    .n_o          (diff_n_o),
    .oe_o         (diff_oe_o),
    .parked_o     (diff_parked)
  );

  // Status, brought into the free-running bus domain
  always_comb begin
    stat_raw[1] = all_bus_parked & (diff_free_cfg_i | diff_parked);
    stat_raw[0] = ~(|bus_parked) & ~diff_parked;
  end

  clkstop_sync #(.WIDTH(STAT_W), .DEPTH(SYNC_DEPTH)) u_stat_sync (
    .clk_i  (bus_free_clk_i),
    .rst_ni (rst_ni),
    .d_i    (stat_raw),
    .q_o    (stat_s)
  );

  assign stopped_o = stat_s[1];
  assign running_o = stat_s[0];

  assert_pair_after_bus_R4: assert property (@(posedge diff_clk_i) disable iff (!rst_ni)
    diff_parked |-> all_bus_parked);

  assert_pair_resumes_first_R7: assert property (@(posedge diff_clk_i) disable iff (!rst_ni)
    $fell(diff_parked) |-> all_bus_parked);

  assert_status_exclusive_R8: assert property (@(posedge bus_free_clk_i) disable iff (!rst_ni)
    !(running_o && stopped_o && !(&bus_free_cfg_i) && !diff_free_cfg_i));
endmodule

// File: tb/clkstop_ctrl_bench.sv
`timescale 1ns/100ps
module clkstop_ctrl_bench;
  localparam int NUM_BUS = 4;
  localparam logic [NUM_BUS-1:0] FREE_CFG = 4'b0010;

  logic fclk = 1'b0;
  logic dclk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_n = 1'b1;
  logic stop_reg = 1'b0;
  logic diff_free = 1'b0;
  logic float_cfg = 1'b0;
  logic [NUM_BUS-1:0] bus_clk;
  logic [NUM_BUS-1:0] bus_out;
  logic dp, dn, doe, stopped, running;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 fclk = ~fclk;
  initial begin
    #1;
    forever #2 dclk = ~dclk;
  end
  assign bus_clk = {NUM_BUS{fclk}};

  clkstop_ctrl #(.NUM_BUS(NUM_BUS)) u_clkstop_ctrl (
    .bus_free_clk_i  (fclk),
    .bus_clk_i       (bus_clk),
    .diff_clk_i      (dclk),
    .rst_ni          (rst_n),
    .stop_n_i        (stop_n),
    .stop_reg_i      (stop_reg),
    .bus_free_cfg_i  (FREE_CFG),
    .diff_free_cfg_i (diff_free),
    .float_cfg_i     (float_cfg),
    .bus_clk_o       (bus_out),
    .diff_p_o        (dp),
    .diff_n_o        (dn),
    .diff_oe_o       (doe),
    .stopped_o       (stopped),
    .running_o       (running)
  );

  // Edge counting and phase width monitors
  int bus_edges [NUM_BUS];
  int diff_edges = 0;
  int glitch_bus = 0;
  int glitch_diff = 0;
  int order_bad = 0;
  logic [NUM_BUS-1:0] prev_bus = '0;
  bit [NUM_BUS-1:0] seen = '0;
  realtime t_last [NUM_BUS];
  logic prev_p = 1'b0;
  bit seen_p = 0;
  realtime tp_last = 0.0;

  initial for (int i = 0; i < NUM_BUS; i++) begin
    bus_edges[i] = 0;
    t_last[i] = 0.0;
  end

  always @(bus_out) begin
    for (int i = 0; i < NUM_BUS; i++) begin
      if (bus_out[i] !== prev_bus[i]) begin
        if (rst_n && seen[i]) begin
          if (bus_out[i] === 1'b1) begin
            if ($realtime - t_last[i] < 4.99) glitch_bus++;
          end else begin
            if ($realtime - t_last[i] < 4.99 || $realtime - t_last[i] > 5.01) glitch_bus++;
          end
        end
        if (bus_out[i] === 1'b1) bus_edges[i]++;
        if (rst_n) seen[i] = 1'b1;
        t_last[i] = $realtime;
      end
    end
    prev_bus = bus_out;
  end

  always @(dp) begin
    if (dp !== prev_p) begin
      if (rst_n && seen_p) begin
        if (dp === 1'b1) begin
          if ($realtime - tp_last < 1.99 || $realtime - tp_last > 2.01) glitch_diff++;
        end else begin
          if ($realtime - tp_last < 1.99) glitch_diff++;
        end
      end
      if (dp === 1'b1) diff_edges++;
      if (rst_n) seen_p = 1;
      tp_last = $realtime;
    end
    prev_p = dp;
  end

  // Ordering monitor, sampling between edges
  initial begin
    int hi_cnt;
    hi_cnt = 0;
    #0.5;
    forever begin
      #1;
      if (rst_n) begin
        if (dn !== ~dp) order_bad++;
        hi_cnt = (dp === 1'b1) ? hi_cnt + 1 : 0;
        if (hi_cnt >= 3 && |(bus_out & ~FREE_CFG)) order_bad++;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Count rising edges in a 100 ns window
  task automatic window(output int stop_e, output int free_e, output int diff_e);
    int b0 [NUM_BUS];
    int d0;
    for (int i = 0; i < NUM_BUS; i++) b0[i] = bus_edges[i];
    d0 = diff_edges;
    #100;
    stop_e = 0;
    free_e = 0;
    for (int i = 0; i < NUM_BUS; i++) begin
      if (FREE_CFG[i]) free_e += bus_edges[i] - b0[i];
      else             stop_e += bus_edges[i] - b0[i];
    end
    diff_e = diff_edges - d0;
  endtask

  task automatic t_reset;
    int s, f, d;
    window(s, f, d);
    check(s >= 27, "R9 stoppable bus clocks run after reset", s, 30);
    check(d >= 24, "R9 pair runs after reset", d, 25);
    check(running === 1'b1 && stopped === 1'b0, "R9 status after reset",
          int'({running, stopped}), 2);
    check(doe === 1'b1, "R9 output-enable after reset", int'(doe), 1);
  endtask

  task automatic t_pin_stop;
    int s, f, d;
    stop_n = 1'b0;
    #300;
    window(s, f, d);
    check(s == 0 && (bus_out & ~FREE_CFG) == '0, "R1 R3 pin stop holds bus clocks low", s, 0);
    check(f >= 9, "R6 free bus clock keeps toggling", f, 10);
    check(d == 0 && dp === 1'b1 && dn === 1'b0, "R4 pair parked true high", d, 0);
    check(doe === 1'b1, "R5 output-enable stays high without float", int'(doe), 1);
    check(stopped === 1'b1 && running === 1'b0, "R8 stopped status", int'({stopped, running}), 2);
  endtask

  task automatic t_resume;
    int s, f, d;
    stop_n = 1'b1;
    stop_reg = 1'b0;
    #300;
    window(s, f, d);
    check(s >= 27 && d >= 24, "R7 all clocks resume", s + d, 55);
    check(running === 1'b1 && stopped === 1'b0, "R8 running status after resume",
          int'({running, stopped}), 2);
  endtask

  task automatic t_reg_stop;
    int s, f, d;
    stop_reg = 1'b1;
    #300;
    window(s, f, d);
    check(s == 0 && d == 0, "R1 register bit stops clocks", s + d, 0);
    t_resume();
  endtask

  task automatic t_float;
    float_cfg = 1'b1;
    #50;
    stop_n = 1'b0;
    #300;
    check(doe === 1'b0, "R5 float releases the pair", int'(doe), 0);
    t_resume();
    check(doe === 1'b1, "R5 output-enable back after resume", int'(doe), 1);
    float_cfg = 1'b0;
    #50;
  endtask

  task automatic t_diff_free;
    int s, f, d;
    diff_free = 1'b1;
    #50;
    stop_n = 1'b0;
    #300;
    window(s, f, d);
    check(d >= 24, "R6 free pair ignores stop", d, 25);
    check(s == 0, "R6 stoppable bus still parks with free pair", s, 0);
    check(stopped === 1'b1, "R8 stopped with free pair", int'(stopped), 1);
    t_resume();
    diff_free = 1'b0;
    #50;
  endtask

  task automatic t_short_pulse;
    int s, f, d;
    int b0;
    b0 = 0;
    for (int i = 0; i < NUM_BUS; i++) if (!FREE_CFG[i]) b0 += bus_edges[i];
    @(posedge fclk);
    #1.3;
    stop_n = 1'b0;
    #3;
    stop_n = 1'b1;
    window(s, f, d);
    check(s >= 27 && running === 1'b1, "R2 pulse between sample edges ignored", s, 30);
    check(d >= 24, "R2 pair unaffected by unsampled pulse", d, 25);
  endtask

  initial begin
    #0.3;
    #40;
    rst_n = 1'b1;
    #100;
    t_reset();
    t_pin_stop();
    t_resume();
    t_reg_stop();
    t_float();
    t_diff_free();
    t_short_pulse();
    check(glitch_bus == 0, "R3 R7 bus phase widths full", glitch_bus, 0);
    check(glitch_diff == 0, "R7 pair phase widths full", glitch_diff, 0);
    check(order_bad == 0, "R4 R7 stop and resume ordering", order_bad, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule